// File: doc/BRIEF.md
# Noise LFSR Generator

This block produces the 12-bit noise waveform of one synthesizer voice. It holds a 23-bit linear feedback shift register. The register advances once each time the oscillator's phase accumulator reports a rising edge on its bit 19. The advance comes a fixed two clock edges after that report, as the stepping logic in the voice has a short pipeline. Eight scattered register bits drive the upper eight bits of the noise word. The lowest four bits of the word are grounded.

A test control stops the oscillator path. While test is held, the stepping pipeline is frozen. If test stays high long enough, a hold timer expires and the register is reseeded to all ones. When the voice mixes noise with another waveform, the mixed 12-bit output is fed back into the register's output taps. This write-back can only clear bits, never set them, so mixed noise decays toward zero.

Top module: `noise_lfsr_gen`

## Requirements
- R1: On each step the register moves every bit up one place, and the new bit 0 is the XOR of the old bits 22 and 17.
- R2: `noise_o` bits 11, 10, 9, 8, 7, 6, 5, 4 carry register bits 20, 18, 14, 11, 9, 5, 2, 0 respectively, and `noise_o[3:0]` is always zero.
- R3: While `rst` is high at a clock edge, the register loads 0x7FFFFF (so `noise_o` = 0xFF0) and any pending step is discarded.
- R4: A rise event sampled at edge k with test low makes the register step at edge k+2 and not at edge k+1.
- R5: A rise event sampled while a step is one edge from firing cancels that step and restarts the two-edge delay.
- R6: While `test_i` is high the register never steps, and a pending step resumes counting where it stopped once `test_i` falls.
- R7: When `test_i` is high for HOLD_CYCLES consecutive edges, the register loads 0x7FFFFF at the last of them. Any edge with `test_i` low restarts this count.
- R8: Write-back uses `wave_sel_i` bit 3 for noise and bits 2..0 for pulse, sawtooth and triangle. When noise and at least one other waveform are selected and test is low, each of the eight tap bits is ANDed with the matching `combo_i` bit (11..4). A cleared bit is never set again by write-back.
- R9: Write-back does not happen on the edge where a pending step fires, so that edge performs a plain step.
- R10: With noise alone, or with noise not selected, `combo_i` has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_i | input | 1 | Test control: freezes stepping, reseeds after the hold time |
| acc_b19_rise_i | input | 1 | One-cycle event: accumulator bit 19 went from 0 to 1 |
| wave_sel_i | input | 4 | Waveform select: bit 3 noise, bit 2 pulse, bit 1 sawtooth, bit 0 triangle |
| combo_i | input | 12 | Combined waveform output fed back to the taps |
| noise_o | output | 12 | Noise waveform word |

## Verification
Directed sequences start from the reseeded state. A single rise event shows whether the step lands at the second edge rather than the first. Back-to-back rise events show whether a pending step is cancelled. A rise event followed by held test shows whether the pipeline freezes, and whether it resumes rather than being cleared. Test runs of exactly HOLD_CYCLES, of one edge less, and interrupted runs separate a correct hold count from an off-by-one or a count that does not restart. Write-back patterns cover noise with pulse, noise alone and non-noise selections, plus write-back aligned with a firing step. Together they show AND-only clearing, correct select decoding and the skip on the firing edge. A long random run then mixes all inputs against a bench model of the register.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;

    localparam int LFSR_W  = 23;
    localparam int WAVE_W  = 12;
    localparam int TAP_N   = 8;
    localparam int TAP_LSB = WAVE_W - TAP_N;
    localparam int FB_HI   = 22;
    localparam int FB_LO   = 17;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [WAVE_W-1:0] wave_t;

    localparam lfsr_t SEED = '1;

    // Waveform select fields; bit 3 noise down to bit 0 triangle.
    typedef struct packed {
        logic noise;
        logic pulse;
        logic saw;
        logic tri_w;
    } wave_sel_t;

    // Register bit feeding output bit TAP_LSB + idx.
    function automatic int tap_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 2;
            2:       return 5;
            3:       return 9;
            4:       return 11;
            5:       return 14;
            6:       return 18;
            default: return 20;
        endcase
    endfunction

    function automatic lfsr_t lfsr_next(input lfsr_t s);
        return {s[LFSR_W-2:0], s[FB_HI] ^ s[FB_LO]};
    endfunction

    // Mask applied by write-back: ones everywhere except taps, which take combo bits.
    function automatic lfsr_t wb_keep(input wave_t c);
        lfsr_t k;
        k = '1;
        for (int i = 0; i < TAP_N; i++) begin
            k[tap_pos(i)] = c[TAP_LSB + i];
        end
        return k;
    endfunction

endpackage

// File: rtl/noise_step_pipe.sv
module noise_step_pipe #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic test_i,
    input  logic rise_i,
    output logic shift_fire_o,
    output logic last_stage_o
);
    localparam int PW = $clog2(DEPTH + 1);

    logic [PW-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (!test_i) begin
            if (rise_i) begin
                stage_q <= PW'(DEPTH);
            end else if (stage_q != '0) begin
                stage_q <= stage_q - PW'(1);
            end
        end
    end

    assign last_stage_o = (stage_q == PW'(1));
    assign shift_fire_o = last_stage_o && !rise_i && !test_i;

endmodule

// File: rtl/noise_seed_timer.sv
module noise_seed_timer #(
    parameter int HOLD_CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic test_i,
    output logic seed_load_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || !test_i) begin
            left_q <= CW'(HOLD_CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - CW'(1);
        end
    end

    assign seed_load_o = test_i && (left_q == CW'(1));

endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core
    import noise_lfsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  seed_load_i,
    input  logic  shift_i,
    input  logic  wb_en_i,
    input  wave_t combo_i,
    output wave_t noise_o
);
    lfsr_t sr_q;
    lfsr_t keep_w;

    assign keep_w = wb_keep(combo_i);

    always_ff @(posedge clk) begin
        if (rst || seed_load_i) begin
            sr_q <= SEED;
        end else if (shift_i) begin
            sr_q <= lfsr_next(sr_q);
        end else if (wb_en_i) begin
            sr_q <= sr_q & keep_w;
        end
    end

    for (genvar g = 0; g < TAP_N; g++) begin : g_tap
        assign noise_o[TAP_LSB + g] = sr_q[tap_pos(g)];
    end
    assign noise_o[TAP_LSB-1:0] = '0;

endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
    import noise_lfsr_pkg::*;
#(
    parameter int HOLD_CYCLES = 32,
    parameter int STEP_DELAY  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        test_i,
    input  logic        acc_b19_rise_i,
    input  logic [3:0]  wave_sel_i,
    input  logic [11:0] combo_i,
    output logic [11:0] noise_o
);
    wave_sel_t sel_w;
    logic      shift_fire_w;
    logic      last_stage_w;
    logic      seed_load_w;
    logic      wb_en_w;

    assign sel_w = wave_sel_t'(wave_sel_i);

    noise_step_pipe #(.DEPTH(STEP_DELAY)) i_pipe (
        .clk          (clk),
        .rst          (rst),
        .test_i       (test_i),
        .rise_i       (acc_b19_rise_i),
        .shift_fire_o (shift_fire_w),
        .last_stage_o (last_stage_w)
    );

    noise_seed_timer #(.HOLD_CYCLES(HOLD_CYCLES)) i_timer (
        .clk         (clk),
        .rst         (rst),
        .test_i      (test_i),
        .seed_load_o (seed_load_w)
    );

    assign wb_en_w = sel_w.noise && (sel_w.pulse || sel_w.saw || sel_w.tri_w)
                     && !test_i && !last_stage_w;

    noise_lfsr_core i_core (
        .clk         (clk),
        .rst         (rst),
        .seed_load_i (seed_load_w),
        .shift_i     (shift_fire_w),
        .wb_en_i     (wb_en_w),
        .combo_i     (combo_i),
        .noise_o     (noise_o)
    );

endmodule

// File: rtl/noise_lfsr_chk.sv
module noise_lfsr_chk (
    input logic        clk,
    input logic        rst,
    input logic        test_i,
    input logic        acc_b19_rise_i,
    input logic [3:0]  wave_sel_i,
    input logic [11:0] combo_i,
    input logic [11:0] noise_o,
    input logic        shift_fire,
    input logic        seed_load,
    input logic        wb_en
);
    AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        noise_o[3:0] == 4'h0); // R2

    AST_NO_EARLY_STEP: assert property (@(posedge clk) disable iff (rst)
        (acc_b19_rise_i && !test_i) |=> !shift_fire); // R4

    AST_TEST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (test_i && !seed_load) |=> $stable(noise_o)); // R6

    AST_WB_AND_ONLY: assert property (@(posedge clk) disable iff (rst)
        wb_en |=> (noise_o[11:4] == ($past(noise_o[11:4]) & $past(combo_i[11:4])))); // R8

    AST_WB_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!(wave_sel_i[3] && (wave_sel_i[2:0] != 3'b000)) && !shift_fire && !seed_load)
        |=> $stable(noise_o)); // R10

    AST_SEED_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> (noise_o == 12'hFF0)); // R7

endmodule

bind noise_lfsr_gen noise_lfsr_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .test_i         (test_i),
    .acc_b19_rise_i (acc_b19_rise_i),
    .wave_sel_i     (wave_sel_i),
    .combo_i        (combo_i),
    .noise_o        (noise_o),
    .shift_fire     (shift_fire_w),
    .seed_load      (seed_load_w),
    .wb_en          (wb_en_w)
);

// File: tb/test_noise_lfsr_gen.sv
module test_noise_lfsr_gen;

    localparam int HOLD = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        test_i = 1'b0;
    logic        rise = 1'b0;
    logic [3:0]  sel = 4'h0;
    logic [11:0] combo = 12'h000;
    logic [11:0] noise_o;

    always #5 clk = ~clk;

    noise_lfsr_gen #(.HOLD_CYCLES(HOLD), .STEP_DELAY(2)) i_noise_lfsr_gen (
        .clk            (clk),
        .rst            (rst),
        .test_i         (test_i),
        .acc_b19_rise_i (rise),
        .wave_sel_i     (sel),
        .combo_i        (combo),
        .noise_o        (noise_o)
    );

    // Bench model built from the requirements
    logic [22:0] m_sr;
    int          m_pipe;
    int          m_cnt;

    function automatic logic [22:0] m_step(input logic [22:0] s);
        return {s[21:0], s[22] ^ s[17]};
    endfunction

    function automatic logic [11:0] m_taps(input logic [22:0] s);
        return {s[20], s[18], s[14], s[11], s[9], s[5], s[2], s[0], 4'h0};
    endfunction

    function automatic logic [22:0] m_wb(input logic [22:0] s, input logic [11:0] c);
        logic [22:0] r;
        r = s;
        r[20] = s[20] & c[11];
        r[18] = s[18] & c[10];
        r[14] = s[14] & c[9];
        r[11] = s[11] & c[8];
        r[9]  = s[9]  & c[7];
        r[5]  = s[5]  & c[6];
        r[2]  = s[2]  & c[5];
        r[0]  = s[0]  & c[4];
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sr = '1;
            m_pipe = 0;
            m_cnt = HOLD;
        end else if (test_i) begin
            if (m_cnt != 0) begin
                if (m_cnt == 1) m_sr = '1;
                m_cnt = m_cnt - 1;
            end
        end else begin
            logic wb_ok;
            m_cnt = HOLD;
            wb_ok = sel[3] && (sel[2:0] != 3'b000) && (m_pipe != 1);
            if (rise) begin
                m_pipe = 2;
            end else if (m_pipe != 0) begin
                if (m_pipe == 1) m_sr = m_step(m_sr);
                m_pipe = m_pipe - 1;
            end
            if (wb_ok) m_sr = m_wb(m_sr, combo);
        end
    end

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input logic [11:0] exp);
        n_chk++;
        if (noise_o !== exp) begin
            n_fail++;
            $display("FAIL %s: noise_o=%h expected %h", tag, noise_o, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic r, input logic [3:0] s, input logic [11:0] c);
        test_i = t;
        rise = r;
        sel = s;
        combo = c;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got %0d expected done", done);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234));
        // R3: reset with a rise event present
        rise = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 reset value", 12'hFF0);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 4'h0, 12'h000);
            chk("R3 no pending step", 12'hFF0);
        end

        // R4 / R1 / R2: single rise, step at second edge
        cyc(0, 1, 4'h0, 12'h000);
        chk("R4 edge k", 12'hFF0);
        cyc(0, 0, 4'h0, 12'h000);
        chk("R4 edge k+1", 12'hFF0);
        cyc(0, 0, 4'h0, 12'h000);
        chk("R4 R1 R2 edge k+2", 12'hFE0);

        // R5: back-to-back rises restart the delay
        for (int i = 0; i < 4; i++) begin
            cyc(0, 1, 4'h0, 12'h000);
            cyc(0, 0, 4'h0, 12'h000);
            cyc(0, 0, 4'h0, 12'h000);
        end
        cyc(0, 1, 4'h0, 12'h000);
        cyc(0, 1, 4'h0, 12'h000);
        chk("R5 cancelled", m_taps(m_sr));
        cyc(0, 0, 4'h0, 12'h000);
        chk("R5 waiting", m_taps(m_sr));
        cyc(0, 0, 4'h0, 12'h000);
        chk("R5 restarted step", m_taps(m_sr));

        // R6: test freezes a pending step, which then resumes
        cyc(0, 1, 4'h0, 12'h000);
        for (int i = 0; i < 3; i++) begin
            cyc(1, 0, 4'h0, 12'h000);
            chk("R6 frozen", m_taps(m_sr));
        end
        cyc(0, 0, 4'h0, 12'h000);
        chk("R6 resume stage", m_taps(m_sr));
        cyc(0, 0, 4'h0, 12'h000);
        chk("R6 resumed step", m_taps(m_sr));

        // R7: hold count, exact length and restart
        for (int i = 0; i < HOLD - 1; i++) cyc(1, 0, 4'h0, 12'h000);
        chk("R7 one short", m_taps(m_sr));
        cyc(1, 0, 4'h0, 12'h000);
        chk("R7 reseed", 12'hFF0);
        for (int i = 0; i < 3; i++) begin
            cyc(0, 1, 4'h0, 12'h000);
            cyc(0, 0, 4'h0, 12'h000);
            cyc(0, 0, 4'h0, 12'h000);
        end
        for (int i = 0; i < HOLD - 1; i++) cyc(1, 0, 4'h0, 12'h000);
        cyc(0, 0, 4'h0, 12'h000);
        for (int i = 0; i < HOLD - 1; i++) cyc(1, 0, 4'h0, 12'h000);
        chk("R7 interrupted", m_taps(m_sr));
        cyc(1, 0, 4'h0, 12'h000);
        chk("R7 reseed after restart", 12'hFF0);

        // R8: AND-only write-back
        cyc(0, 0, 4'b1100, 12'h0F0);
        chk("R8 clear", 12'h0F0);
        cyc(0, 0, 4'b1001, 12'hFFF);
        chk("R8 no set", 12'h0F0);

        // R10: selections without write-back
        cyc(0, 0, 4'b1000, 12'h000);
        chk("R10 noise alone", 12'h0F0);
        cyc(0, 0, 4'b0111, 12'h000);
        chk("R10 noise off", 12'h0F0);

        // R9: write-back skipped on firing edge
        for (int i = 0; i < HOLD; i++) cyc(1, 0, 4'h0, 12'h000);
        cyc(0, 1, 4'h0, 12'h000);
        cyc(0, 0, 4'h0, 12'h000);
        cyc(0, 0, 4'b1100, 12'h000);
        chk("R9 plain step", 12'hFE0);

        // Random run against the model
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 97) == 0) begin
                int len = 1 + ($urandom % (HOLD + 4));
                for (int j = 0; j < len; j++) begin
                    cyc(1, ($urandom % 6) == 0, 4'($urandom), 12'($urandom));
                    chk("R6 R7 random", m_taps(m_sr));
                end
            end
            cyc(0, ($urandom % 5) == 0,
                (($urandom % 4) == 0) ? 4'($urandom) : 4'h0,
                12'($urandom) | 12'hF00);
            chk("R1 random", m_taps(m_sr));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule